// File: doc/BRIEF.md
# Dual Store-Queue Burst Write Buffer

This block gives a processor two small write-combining buffers of eight 32-bit longwords each (32 bytes per buffer). The processor writes longwords or quadwords into them with ordinary stores to a reserved address window. It then issues a flush command that empties one buffer to external memory as a single aligned 32-byte burst. One address bit picks the buffer. Software can fill one buffer while the other drains, and only the buffer that is draining holds off new stores.

The memory side is a plain burst-write master. It presents one 32-byte-aligned address under a valid/ready handshake and then eight 32-bit data beats, slot 0 first, each under its own valid/ready handshake. The final beat is marked. External address bits [28:10] come from a configuration input that stands in for a translation result. Bits [9:5] come straight from the flush address. Bits [4:0] and [31:29] are zero.

Top module: `sq_burst_buf`

## Requirements
- R1: A store or flush is in the window only when address bits [31:26] equal 6'b111000. Bits [25:6] have no effect on which queue, slot or data is used.
- R2: Address bit [5] selects the queue (0 selects queue 0, 1 selects queue 1). Bits [4:2] select the longword slot 0..7. A longword store writes st_data[31:0] into that slot.
- R3: With st_quad=1, a store writes st_data[31:0] to the addressed slot and st_data[63:32] to the next slot. A quadword whose address bit [2] is 1 is ignored and flagged on err_pulse.
- R4: A store with bits [1:0] not 00, or with an address outside the window, changes no queue and does not stall. A flush outside the window is ignored in the same way. Either case raises err_pulse for exactly the one cycle after the clock edge that sampled it.
- R5: A flush accepted while the burst master is idle raises m_avalid in the second cycle after the cycle in which the flush was presented.
- R6: The burst address is {3'b000, cfg_page, flush address bits [9:5], 5'b00000}. cfg_page is sampled when the burst starts.
- R7: After the address handshake, the eight slots of the queue go out in ascending order, slot 0 first. A beat advances only on a cycle with m_dvalid and m_dready both high. m_dlast is high on the eighth beat only. m_avalid and m_dvalid are never high together, and each holds its payload while its ready is low.
- R8: While one queue is waiting or being transferred, a valid store to the other queue is accepted with st_stall low.
- R9: From flush acceptance until the last beat of that queue's burst is accepted, a valid store or flush to that queue is held with st_stall or fl_stall high. It is accepted in the cycle after the last beat.
- R10: A flush of the other queue accepted during a burst is queued. Its burst starts after the running burst ends, so bursts leave in the order their flushes were accepted.
- R11: During and right after reset, m_avalid, m_dvalid, m_dlast, st_stall, fl_stall and err_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store address |
| st_data | input | 64 | Store data; the low half goes to the addressed slot |
| st_quad | input | 1 | 1 = quadword store, 0 = longword store |
| st_stall | output | 1 | Store held this cycle |
| fl_valid | input | 1 | Flush request |
| fl_addr | input | 32 | Flush address |
| fl_stall | output | 1 | Flush held this cycle |
| cfg_page | input | 19 | External address bits [28:10] |
| err_pulse | output | 1 | One-cycle flag for an ignored store or flush |
| m_avalid | output | 1 | Burst address valid |
| m_aaddr | output | 32 | Burst start address |
| m_aready | input | 1 | Burst address accepted |
| m_dvalid | output | 1 | Data beat valid |
| m_wdata | output | 32 | Data beat |
| m_dlast | output | 1 | Final beat of the burst |
| m_dready | input | 1 | Data beat accepted |

## Verification
The bench targets the moments where the two queues overlap. It checks a store to the idle queue during a burst, which a design that stalls on any activity would hold back. It checks a store to the draining queue, which a design with a wrong interlock would let corrupt the beats still to be sent. It checks a second flush queued behind a running burst, which a design without a pending record would drop or send out of order. It also checks an illegal quadword at an odd slot, a misaligned longword and an out-of-window store. A design that wrote any of these would show the stray data in a later burst, and a design with wrong error timing would miss the one-cycle error pulse. The ready inputs toggle irregularly, so a master that advances a beat without a handshake sends the wrong longword.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_t;

   localparam logic [5:0] SQB_WIN_TAG = 6'b111000;
endpackage

// File: rtl/sqb_decode.sv
module sqb_decode #(
   parameter int         ADDR_W = 32,
   parameter int         SLOT_W = 3,
   parameter logic [5:0] TAG    = 6'b111000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win,
   output logic              aligned,
   output logic              pair_ok,
   output logic              qsel,
   output logic [SLOT_W-1:0] slot,
   output logic [4:0]        blk
);
   assign in_win  = (addr[ADDR_W-1 -: 6] == TAG);
   assign aligned = (addr[1:0] == 2'b00);
   assign pair_ok = ~addr[2];
   assign qsel    = addr[SLOT_W+2];
   assign slot    = addr[SLOT_W+1:2];
   assign blk     = addr[9:5];
endmodule

// File: rtl/sqb_queue.sv
module sqb_queue #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 8,
   localparam int SLOT_W = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_pair,
   input  logic [SLOT_W-1:0]   wr_slot,
   input  logic [2*WORD_W-1:0] wr_data,
   input  logic [SLOT_W-1:0]   rd_slot,
   output logic [WORD_W-1:0]   rd_data
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [SLOT_W-1:0] nxt_slot;

   assign nxt_slot = wr_slot + SLOT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_slot] <= wr_data[WORD_W-1:0];
         if (wr_pair) mem[nxt_slot] <= wr_data[2*WORD_W-1:WORD_W];
      end
   end

   assign rd_data = mem[rd_slot];
endmodule

// File: rtl/sqb_burst.sv
module sqb_burst
   import sqb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PAGE_W = 19,
   parameter int DEPTH  = 8,
   localparam int SLOT_W = $clog2(DEPTH),
   localparam int PAD_W  = ADDR_W - PAGE_W - 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        req,
   input  logic [1:0][4:0]   blk,
   input  logic [PAGE_W-1:0] cfg_page,
   output logic              m_avalid,
   output logic [ADDR_W-1:0] m_aaddr,
   input  logic              m_aready,
   output logic              m_dvalid,
   output logic              m_dlast,
   input  logic              m_dready,
   output logic              cur,
   output logic [SLOT_W-1:0] beat,
   output logic              done
);
   phase_t phase;
   logic   last_q;
   logic   pick;
   logic   any_req;
   logic   end_beat;

   assign any_req  = |req;
   assign pick     = req[~last_q] ? ~last_q : last_q;
   assign end_beat = (beat == SLOT_W'(DEPTH-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cur     <= 1'b0;
         last_q  <= 1'b1;
         beat    <= '0;
         m_aaddr <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (any_req) begin
               phase   <= PH_ADDR;
               cur     <= pick;
               last_q  <= pick;
               m_aaddr <= {{PAD_W{1'b0}}, cfg_page, blk[pick], 5'b00000};
            end
            PH_ADDR: if (m_aready) begin
               phase <= PH_DATA;
               beat  <= '0;
            end
            PH_DATA: if (m_dready) begin
               if (end_beat) phase <= PH_IDLE;
               else          beat  <= beat + SLOT_W'(1);
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign m_avalid = (phase == PH_ADDR);
   assign m_dvalid = (phase == PH_DATA);
   assign m_dlast  = m_dvalid & end_beat;
   assign done     = m_dvalid & m_dready & end_beat;
endmodule

// File: rtl/sq_burst_buf.sv
module sq_burst_buf
   import sqb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int DEPTH  = 8,
   parameter int PAGE_W = 19,
   localparam int SLOT_W = $clog2(DEPTH),
   localparam int NQ     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                st_valid,
   input  logic [ADDR_W-1:0]   st_addr,
   input  logic [2*WORD_W-1:0] st_data,
   input  logic                st_quad,
   output logic                st_stall,
   input  logic                fl_valid,
   input  logic [ADDR_W-1:0]   fl_addr,
   output logic                fl_stall,
   input  logic [PAGE_W-1:0]   cfg_page,
   output logic                err_pulse,
   output logic                m_avalid,
   output logic [ADDR_W-1:0]   m_aaddr,
   input  logic                m_aready,
   output logic                m_dvalid,
   output logic [WORD_W-1:0]   m_wdata,
   output logic                m_dlast,
   input  logic                m_dready
);
   if (DEPTH * WORD_W != 256) begin : g_bad_geom
      $error("queue must hold exactly 32 bytes");
   end
   if (SLOT_W + 4 > 10) begin : g_bad_slot
      $error("slot and queue bits must sit below bit 9");
   end
   if (ADDR_W != PAGE_W + 13) begin : g_bad_page
      $error("page width must leave three zero top bits");
   end

   logic              s_win, s_al, s_pair, s_q;
   logic [SLOT_W-1:0] s_slot;
   logic [4:0]        s_blk;
   logic              f_win, f_al, f_pair, f_q;
   logic [SLOT_W-1:0] f_slot;
   logic [4:0]        f_blk;

   sqb_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .TAG(SQB_WIN_TAG)) u_st_dec (
      .addr(st_addr), .in_win(s_win), .aligned(s_al), .pair_ok(s_pair),
      .qsel(s_q), .slot(s_slot), .blk(s_blk));

   sqb_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .TAG(SQB_WIN_TAG)) u_fl_dec (
      .addr(fl_addr), .in_win(f_win), .aligned(f_al), .pair_ok(f_pair),
      .qsel(f_q), .slot(f_slot), .blk(f_blk));

   logic [NQ-1:0]        busy;
   logic [NQ-1:0][4:0]   blk_q;
   logic                 st_legal, st_hit, st_wr, st_bad;
   logic                 fl_hit, fl_take, fl_bad;
   logic                 cur, done;
   logic [SLOT_W-1:0]    beat;
   logic [NQ-1:0][WORD_W-1:0] q_rd;

   assign st_legal = s_win & s_al & (~st_quad | s_pair);
   assign st_hit   = st_valid & st_legal;
   assign st_stall = st_hit & busy[s_q];
   assign st_wr    = st_hit & ~busy[s_q];
   assign st_bad   = st_valid & ~st_legal;

   assign fl_hit   = fl_valid & f_win;
   assign fl_stall = fl_hit & busy[f_q];
   assign fl_take  = fl_hit & ~busy[f_q];
   assign fl_bad   = fl_valid & ~f_win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= '0;
         blk_q     <= '0;
         err_pulse <= 1'b0;
      end else begin
         err_pulse <= st_bad | fl_bad;
         for (int q = 0; q < NQ; q++) begin
            if (fl_take && f_q == q[0]) begin
               busy[q]  <= 1'b1;
               blk_q[q] <= f_blk;
            end else if (done && cur == q[0]) begin
               busy[q]  <= 1'b0;
            end
         end
      end
   end

   for (genvar g = 0; g < NQ; g++) begin : g_queue
      sqb_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_queue (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (st_wr && s_q == g[0]),
         .wr_pair (st_quad),
         .wr_slot (s_slot),
         .wr_data (st_data),
         .rd_slot (beat),
         .rd_data (q_rd[g]));
   end

   sqb_burst #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (busy),
      .blk      (blk_q),
      .cfg_page (cfg_page),
      .m_avalid (m_avalid),
      .m_aaddr  (m_aaddr),
      .m_aready (m_aready),
      .m_dvalid (m_dvalid),
      .m_dlast  (m_dlast),
      .m_dready (m_dready),
      .cur      (cur),
      .beat     (beat),
      .done     (done));

   assign m_wdata = q_rd[cur];
endmodule

// File: rtl/sqb_checker.sv
module sqb_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        st_valid,
   input logic [31:0] st_addr,
   input logic        st_stall,
   input logic        fl_valid,
   input logic        err_pulse,
   input logic        m_avalid,
   input logic [31:0] m_aaddr,
   input logic        m_aready,
   input logic        m_dvalid,
   input logic [31:0] m_wdata,
   input logic        m_dlast,
   input logic        m_dready
);
   int unsigned beats_seen;

   always_ff @(posedge clk) begin
      if (!rst_n)                      beats_seen <= 0;
      else if (m_avalid && m_aready)   beats_seen <= 0;
      else if (m_dvalid && m_dready)   beats_seen <= beats_seen + 1;
   end

   AST_ADDR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      m_avalid |-> (m_aaddr[4:0] == 5'd0 && m_aaddr[31:29] == 3'd0)); // R6
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_avalid && !m_aready) |=> (m_avalid && $stable(m_aaddr))); // R7
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_dvalid && !m_dready) |=> (m_dvalid && $stable(m_wdata) && $stable(m_dlast))); // R7
   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_avalid && m_dvalid)); // R7
   AST_LAST_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
      (m_dvalid && m_dlast) |-> (beats_seen == 7)); // R7
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(st_valid || fl_valid)); // R4
   AST_STALL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      st_stall |-> (st_valid && st_addr[31:26] == 6'b111000 && st_addr[1:0] == 2'b00)); // R9
endmodule

bind sq_burst_buf sqb_checker u_sqb_checker (
   .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
   .st_stall(st_stall), .fl_valid(fl_valid), .err_pulse(err_pulse),
   .m_avalid(m_avalid), .m_aaddr(m_aaddr), .m_aready(m_aready),
   .m_dvalid(m_dvalid), .m_wdata(m_wdata), .m_dlast(m_dlast),
   .m_dready(m_dready));

// File: tb/sq_burst_buf_bench.sv
module sq_burst_buf_bench;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = CLK_PERIOD / 4;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0;
   logic [31:0] st_addr = '0;
   logic [63:0] st_data = '0;
   logic        st_quad = 1'b0;
   logic        st_stall;
   logic        fl_valid = 1'b0;
   logic [31:0] fl_addr = '0;
   logic        fl_stall;
   logic [18:0] cfg_page = '0;
   logic        err_pulse;
   logic        m_avalid;
   logic [31:0] m_aaddr;
   logic        m_aready = 1'b0;
   logic        m_dvalid;
   logic [31:0] m_wdata;
   logic        m_dlast;
   logic        m_dready = 1'b0;

   sq_burst_buf u_sq_burst_buf (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
      .st_data(st_data), .st_quad(st_quad), .st_stall(st_stall),
      .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_stall(fl_stall),
      .cfg_page(cfg_page), .err_pulse(err_pulse), .m_avalid(m_avalid),
      .m_aaddr(m_aaddr), .m_aready(m_aready), .m_dvalid(m_dvalid),
      .m_wdata(m_wdata), .m_dlast(m_dlast), .m_dready(m_dready));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic bit st_legal(input logic [31:0] a, input logic quad);
      return a[31:26] == 6'b111000 && a[1:0] == 2'b00 && (!quad || !a[2]);
   endfunction

   // ---------------- reference model ----------------
   logic [31:0] mq [2][8];
   bit          mbusy [2];
   logic [4:0]  mblk [2];
   int          mph, mcur, mlast, mbeat;
   logic [31:0] maddr;
   bit          merr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int q = 0; q < 2; q++) begin
            mbusy[q] = 0; mblk[q] = '0;
            for (int s = 0; s < 8; s++) mq[q][s] = '0;
         end
         mph = 0; mcur = 0; mlast = 1; mbeat = 0; maddr = '0; merr = 0;
      end else begin
         bit nb [2];
         bit ne;
         int pk;
         nb[0] = mbusy[0]; nb[1] = mbusy[1]; ne = 0;
         if (st_valid) begin
            if (st_legal(st_addr, st_quad)) begin
               int q, s;
               q = st_addr[5]; s = st_addr[4:2];
               if (!mbusy[q]) begin
                  mq[q][s] = st_data[31:0];
                  if (st_quad) mq[q][s+1] = st_data[63:32];
               end
            end else ne = 1;
         end
         if (fl_valid) begin
            if (fl_addr[31:26] == 6'b111000) begin
               int q;
               q = fl_addr[5];
               if (!mbusy[q]) begin nb[q] = 1; mblk[q] = fl_addr[9:5]; end
            end else ne = 1;
         end
         if (mph == 0) begin
            pk = mbusy[1-mlast] ? 1 - mlast : (mbusy[mlast] ? mlast : -1);
            if (pk >= 0) begin
               mph = 1; mcur = pk; mlast = pk;
               maddr = {3'b000, cfg_page, mblk[pk], 5'b00000};
            end
         end else if (mph == 1) begin
            if (m_aready) begin mph = 2; mbeat = 0; end
         end else if (m_dready) begin
            if (mbeat == 7) begin nb[mcur] = 0; mph = 0; end
            else mbeat++;
         end
         mbusy[0] = nb[0]; mbusy[1] = nb[1]; merr = ne;
      end
   end

   // ---------------- per-cycle comparison and capture ----------------
   logic [31:0] cap_addr [8];
   logic [31:0] cap_data [8][8];
   int na = 0;
   int nd = 0;

   always @(negedge clk) begin
      #QTR;
      if (rst_n) begin
         check("R9 st_stall", st_stall,
               st_valid && st_legal(st_addr, st_quad) && mbusy[st_addr[5]]);
         check("R9 fl_stall", fl_stall,
               fl_valid && fl_addr[31:26] == 6'b111000 && mbusy[fl_addr[5]]);
         check("R4 err_pulse", err_pulse, merr);
         check("R5 m_avalid", m_avalid, mph == 1);
         if (mph == 1) check("R6 m_aaddr", m_aaddr, maddr);
         check("R7 m_dvalid", m_dvalid, mph == 2);
         check("R7 m_dlast", m_dlast, mph == 2 && mbeat == 7);
         if (mph == 2) check("R7 m_wdata", m_wdata, mq[mcur][mbeat]);
         if (m_avalid && m_aready && na < 8) begin cap_addr[na] = m_aaddr; na++; end
         if (m_dvalid && m_dready && nd < 64) begin cap_data[nd/8][nd%8] = m_wdata; nd++; end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         m_aready = rst_n && ($urandom_range(0, 2) != 0);
         m_dready = rst_n && ($urandom_range(0, 3) != 0);
      end
   end

   // ---------------- driver tasks ----------------
   task automatic put(input logic [31:0] a, input logic [63:0] d, input logic quad,
                      output int stalls);
      @(negedge clk);
      st_addr = a; st_data = d; st_quad = quad; st_valid = 1'b1; stalls = 0;
      #QTR;
      while (st_stall) begin stalls++; @(negedge clk); #QTR; end
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic flush(input logic [31:0] a, output int stalls);
      @(negedge clk);
      fl_addr = a; fl_valid = 1'b1; stalls = 0;
      #QTR;
      while (fl_stall) begin stalls++; @(negedge clk); #QTR; end
      @(negedge clk);
      fl_valid = 1'b0;
   endtask

   task automatic wait_bursts(input int n);
      while (nd < 8 * n) @(negedge clk);
   endtask

   function automatic logic [31:0] sq_addr(input logic [15:0] junk, input logic [4:0] blk,
                                           input logic [4:0] low);
      return {6'b111000, junk, blk, low};
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog: bursts done actual=%0d expected=5", nd / 8);
      wrap_up();
   end

   // ---------------- directed scenarios ----------------
   initial begin
      int stl;
      repeat (3) @(posedge clk);
      @(negedge clk); #QTR;
      check("R11 avalid in reset", m_avalid, 0);
      check("R11 dvalid in reset", m_dvalid, 0);
      check("R11 dlast in reset", m_dlast, 0);
      check("R11 err in reset", err_pulse, 0);
      check("R11 stalls in reset", {st_stall, fl_stall}, 0);
      @(negedge clk); rst_n = 1'b1;
      cfg_page = 19'h5A5A5;
      @(negedge clk); #QTR;
      check("R11 avalid after reset", m_avalid, 0);

      // R1 R2: longwords to queue 0 with junk in bits [25:6]
      for (int i = 0; i < 8; i++)
         put(sq_addr(16'h1234 ^ 16'(i * 16'h0101), {4'(i + 3), 1'b0}, {i[2:0], 2'b00}),
             {32'hFFFF_FFFF, 32'hA000_0000 + 32'(i)}, 1'b0, stl);
      flush(sq_addr(16'hBEEF, 5'h0A, 5'h1F), stl);
      #QTR; check("R5 no address one cycle after flush", m_avalid, 0);
      @(negedge clk); #QTR; check("R5 address two cycles after flush", m_avalid, 1);
      wait_bursts(1);
      check("R6 burst0 address", cap_addr[0], {3'b000, 19'h5A5A5, 5'h0A, 5'b0});
      for (int i = 0; i < 8; i++)
         check("R1 R2 burst0 data", cap_data[0][i], 32'hA000_0000 + 32'(i));

      // R3 R4: quadwords, illegal quad, misaligned and out-of-window stores to queue 1
      for (int s = 0; s < 8; s += 2)
         put(sq_addr(16'h0F0F, {3'b000, 1'b0, 1'b1}, {s[2:0], 2'b00}),
             {32'hB000_0001 + 32'(s), 32'hB000_0000 + 32'(s)}, 1'b1, stl);
      put(sq_addr(16'h0, 5'h01, {3'd3, 2'b00}), 64'hDEAD_0004_DEAD_0003, 1'b1, stl);
      #QTR; check("R3 odd-slot quadword flagged", err_pulse, 1);
      put(sq_addr(16'h0, 5'h01, {3'd1, 2'b01}), 64'hDEAD_0001, 1'b0, stl);
      #QTR; check("R4 misaligned store flagged", err_pulse, 1);
      put({6'b111001, 16'h0, 5'h01, 3'd2, 2'b00}, 64'hDEAD_0002, 1'b0, stl);
      #QTR; check("R4 out-of-window store flagged", err_pulse, 1);
      check("R4 out-of-window store not stalled", stl, 0);
      cfg_page = 19'h01234;

      // R8 R9 R10: overlap of the two queues
      flush(sq_addr(16'h0, 5'h13, 5'h0), stl);
      put(sq_addr(16'h7777, 5'h00, {3'd3, 2'b00}), 64'hC000_0003, 1'b0, stl);
      check("R8 store to idle queue during burst", stl, 0);
      flush(sq_addr(16'h0, 5'h04, 5'h0), stl);
      check("R10 second flush accepted while busy elsewhere", stl, 0);
      put(sq_addr(16'h0, 5'h01, 5'h00), 64'hC100_0000, 1'b0, stl);
      check("R9 store to draining queue held", stl > 0, 1);
      flush(sq_addr(16'h0, 5'h1F, 5'h0), stl);
      flush(sq_addr(16'h0, 5'h01, 5'h0), stl);
      check("R9 flush to busy queue held", stl > 0, 1);
      wait_bursts(5);

      check("R10 burst1 is queue 1", cap_addr[1], {3'b000, 19'h01234, 5'h13, 5'b0});
      check("R10 burst2 is queue 0", cap_addr[2], {3'b000, 19'h01234, 5'h04, 5'b0});
      check("R10 burst3 is queue 1", cap_addr[3], {3'b000, 19'h01234, 5'h1F, 5'b0});
      check("R6 burst4 address", cap_addr[4], {3'b000, 19'h01234, 5'h01, 5'b0});
      for (int i = 0; i < 8; i++) begin
         check("R3 R4 burst1 data", cap_data[1][i], 32'hB000_0000 + 32'(i));
         check("R8 burst2 data", cap_data[2][i],
               i == 3 ? 32'hC000_0003 : 32'hA000_0000 + 32'(i));
         check("R9 burst3 data", cap_data[3][i],
               i == 0 ? 32'hC100_0000 : 32'hB000_0000 + 32'(i));
      end
      repeat (4) @(negedge clk);
      wrap_up();
   end
endmodule